// File: doc/BRIEF.md
# Synchronous BCD Decade Counter

This block is a single decimal digit counter. It holds a 4-bit binary-coded decimal value and, on each rising clock edge where the count enable is high, advances it by one. After nine it wraps to zero. All four state bits share one clock. The next state is formed by toggle logic in exclusive-OR form: each bit flips when a small AND/OR term of the present bits is true.

A carry output goes high while the digit is nine and counting is enabled. Feeding it into the enable of the next digit chains decades into a multi-digit synchronous counter. Codes ten to fifteen never occur in normal counting, but a disturbance can leave the register holding one. A combinational flag marks such a code. The block always climbs back into the legal range by itself.

By default, the same toggle equations carry an illegal code back within two enabled edges. A parameter can instead force any illegal code to zero on the next enabled edge. A second parameter chooses between an asynchronous and a synchronous reset. Either reset sets the digit to zero.

Top module: `bcd_decade_counter`

## Requirements
- R1: While `rst` is high, the digit becomes 0000 (at once with the asynchronous variant, at the next clock edge with the synchronous one), and it reads 0000 once reset has been held for a clock edge.
- R2: On a rising edge with `cnt_en` high, a digit from 0 to 8 increases by one and digit 9 (1001) becomes 0 (0000).
- R3: On a rising edge with `cnt_en` low, the digit keeps its value, whether it is legal or illegal.
- R4: `carry_out` is high exactly when `cnt_en` is high and the digit is 9 (1001). It stays low for every other code, including the odd illegal codes 11, 13 and 15.
- R5: `bad_code` is high exactly when the digit holds 10 to 15 (bit 3 set together with bit 2 or bit 1), and low for 0 to 9.
- R6: With `FAST_RECOVERY` = 0, an enabled edge takes illegal codes along fixed pairs: 10→11, 11→6, 12→13, 13→4, 14→15, 15→2.
- R7: With `FAST_RECOVERY` = 1, an enabled edge takes any illegal code to 0. Legal counting, hold and carry are the same as with `FAST_RECOVERY` = 0.
- R8: With `FAST_RECOVERY` = 0, any illegal code reaches a legal code within two enabled edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Active-high reset to 0000 (asynchronous or synchronous, set by parameter) |
| cnt_en | input | 1 | Count enable; low holds the digit |
| digit | output | 4 | Present BCD digit, bit 0 has weight 1 |
| carry_out | output | 1 | High when the digit is 9 and counting is enabled |
| bad_code | output | 1 | High when the digit holds an illegal code 10 to 15 |

## Verification
Illegal codes cannot be reached through the ports, because reset and counting only ever produce 0 to 9. The bench therefore imitates a disturbance. It holds reset for two edges, then drops reset and, in the same low clock phase, briefly forces the state register to each code from 10 to 15 before releasing it. It then follows the next two edges on two instances side by side: one uses equation recovery and the other uses one-cycle recovery. It checks the pair paths, the return to zero, the flag, that the carry stays low on odd illegal codes, and that an illegal code holds while the enable is low.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
   localparam int DIGIT_W = 4;
   typedef logic [DIGIT_W-1:0] bcd_t;
   localparam bcd_t BCD_ZERO = 4'd0;
   localparam bcd_t BCD_NINE = 4'd9;
   // bit positions by decimal weight
   localparam int B1 = 0;
   localparam int B2 = 1;
   localparam int B4 = 2;
   localparam int B8 = 3;
endpackage

// File: rtl/bcd_toggle_logic.sv
module bcd_toggle_logic
   import bcd_pkg::*;
(
   input  bcd_t q,
   input  logic en,
   output bcd_t tgl
);
   logic carry_lo;
   logic ninth_wrap;
   logic mid_wrap;

   assign carry_lo   = q[B1] & q[B2];
   assign ninth_wrap = q[B1] & q[B8];
   assign mid_wrap   = carry_lo & q[B4];

   always_comb begin
      tgl      = '0;
      tgl[B1]  = en;
      tgl[B2]  = en & q[B1] & ~q[B8];
      tgl[B4]  = en & carry_lo;
      tgl[B8]  = en & (ninth_wrap | mid_wrap);
   end
endmodule

// File: rtl/bcd_code_decode.sv
module bcd_code_decode
   import bcd_pkg::*;
(
   input  bcd_t q,
   input  logic en,
   output logic illegal,
   output logic wrap_now
);
   logic is_nine;

   assign illegal  = q[B8] & (q[B4] | q[B2]);
   assign is_nine  = q[B8] & ~q[B4] & ~q[B2] & q[B1];
   assign wrap_now = en & is_nine;
endmodule

// File: rtl/bcd_state_reg.sv
module bcd_state_reg
   import bcd_pkg::*;
#(
   parameter bit ASYNC_RESET = 1'b1
)(
   input  logic clk,
   input  logic rst,
   input  bcd_t d,
   output bcd_t q
);
   bcd_t state_q;

   generate
      if (ASYNC_RESET) begin : g_async
         always_ff @(posedge clk or posedge rst) begin
            if (rst) state_q <= BCD_ZERO;
            else     state_q <= d;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (rst) state_q <= BCD_ZERO;
            else     state_q <= d;
         end
      end
   endgenerate

   assign q = state_q;
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
   import bcd_pkg::*;
#(
   parameter int WIDTH         = 4,
   parameter bit FAST_RECOVERY = 1'b0,
   parameter bit ASYNC_RESET   = 1'b1
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             cnt_en,
   output logic [WIDTH-1:0] digit,
   output logic             carry_out,
   output logic             bad_code
);
   generate
      if (WIDTH != DIGIT_W) begin : g_bad_width
         $error("bcd_decade_counter: WIDTH must be 4");
      end
   endgenerate

   bcd_t cur_q;
   bcd_t tgl;
   bcd_t eq_next;
   bcd_t nxt;
   logic illegal;
   logic wrap_now;

   bcd_toggle_logic u_tgl (
      .q   (cur_q),
      .en  (cnt_en),
      .tgl (tgl)
   );

   bcd_code_decode u_dec (
      .q        (cur_q),
      .en       (cnt_en),
      .illegal  (illegal),
      .wrap_now (wrap_now)
   );

   assign eq_next = cur_q ^ tgl;

   generate
      if (FAST_RECOVERY) begin : g_fast
         assign nxt = (illegal & cnt_en) ? BCD_ZERO : eq_next;
      end else begin : g_equation
         assign nxt = eq_next;
      end
   endgenerate

   bcd_state_reg #(.ASYNC_RESET(ASYNC_RESET)) u_reg (
      .clk (clk),
      .rst (rst),
      .d   (nxt),
      .q   (cur_q)
   );

   assign digit     = cur_q;
   assign carry_out = wrap_now;
   assign bad_code  = illegal;
endmodule

// File: rtl/bcd_decade_counter_chk.sv
module bcd_decade_counter_chk #(
   parameter bit FAST_RECOVERY = 1'b0
)(
   input logic       clk,
   input logic       rst,
   input logic       cnt_en,
   input logic [3:0] digit,
   input logic       carry_out,
   input logic       bad_code
);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      (rst && $past(rst)) |-> digit == 4'd0);

   // R2
   step_up_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_en && digit < 4'd9) |=> digit == $past(digit) + 4'd1);

   // R2
   carry_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      carry_out |=> digit == 4'd0);

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !cnt_en |=> $stable(digit));

   // R4
   carry_legal_chk: assert property (@(posedge clk) disable iff (rst)
      carry_out |-> (!bad_code && cnt_en));

   // R5
   flag_range_chk: assert property (@(posedge clk) disable iff (rst)
      bad_code == (digit >= 4'd10));

   generate
      if (FAST_RECOVERY) begin : g_fast_chk
         // R7
         fast_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt_en && bad_code) |=> digit == 4'd0);
      end else begin : g_eq_chk
         // R6
         even_pair_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt_en && bad_code && !digit[0]) |=> (bad_code && digit[0]));
         // R8
         odd_exit_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt_en && bad_code && digit[0]) |=> !bad_code);
      end
   endgenerate
endmodule

bind bcd_decade_counter bcd_decade_counter_chk #(.FAST_RECOVERY(FAST_RECOVERY)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cnt_en    (cnt_en),
   .digit     (digit),
   .carry_out (carry_out),
   .bad_code  (bad_code)
);

// File: tb/sim_bcd_decade_counter.sv
`timescale 1ns/1ps
module sim_bcd_decade_counter;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   logic [3:0] d0, d1;
   logic c0, c1, i0, i1;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bcd_decade_counter #(.FAST_RECOVERY(1'b0)) u0 (
      .clk(clk), .rst(rst), .cnt_en(en), .digit(d0), .carry_out(c0), .bad_code(i0));
   bcd_decade_counter #(.FAST_RECOVERY(1'b1)) u1 (
      .clk(clk), .rst(rst), .cnt_en(en), .digit(d1), .carry_out(c1), .bad_code(i1));

   // {cnt_en, expected carry before edge, expected digit after edge}
   localparam logic [5:0] VEC [15] = '{
      {1'b1, 1'b0, 4'd1}, {1'b1, 1'b0, 4'd2}, {1'b1, 1'b0, 4'd3},
      {1'b1, 1'b0, 4'd4}, {1'b1, 1'b0, 4'd5}, {1'b1, 1'b0, 4'd6},
      {1'b1, 1'b0, 4'd7}, {1'b1, 1'b0, 4'd8}, {1'b1, 1'b0, 4'd9},
      {1'b0, 1'b0, 4'd9}, {1'b1, 1'b1, 4'd0}, {1'b1, 1'b0, 4'd1},
      {1'b0, 1'b0, 4'd1}, {1'b0, 1'b0, 4'd1}, {1'b1, 1'b0, 4'd2}
   };

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // R6 pair table, legal codes per R2
   function automatic logic [3:0] eq_step(input logic [3:0] c);
      case (c)
         4'd10: eq_step = 4'd11;
         4'd11: eq_step = 4'd6;
         4'd12: eq_step = 4'd13;
         4'd13: eq_step = 4'd4;
         4'd14: eq_step = 4'd15;
         4'd15: eq_step = 4'd2;
         4'd9:  eq_step = 4'd0;
         default: eq_step = c + 4'd1;
      endcase
   endfunction

   // hold reset two edges, then release it and upset the state register
   task automatic upset(input logic [3:0] code, input logic en_v);
      @(negedge clk);
      rst = 1'b1;
      en  = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      en  = en_v;
      force u0.u_reg.state_q = code;
      force u1.u_reg.state_q = code;
      #0.5;
      release u0.u_reg.state_q;
      release u1.u_reg.state_q;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [3:0] mid;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset u0", d0, 4'd0);
      check("R1 reset u1", d1, 4'd0);
      check("R5 flag after reset", {3'b0, i0}, 4'd0);
      @(negedge clk);
      rst = 1'b0;

      foreach (VEC[k]) begin
         @(negedge clk);
         en = VEC[k][5];
         #1;
         check("R4 carry u0", {3'b0, c0}, {3'b0, VEC[k][4]});
         check("R4 carry u1", {3'b0, c1}, {3'b0, VEC[k][4]});
         @(posedge clk);
         #1;
         check(VEC[k][5] ? "R2 count u0" : "R3 hold u0", d0, VEC[k][3:0]);
         check("R7 legal count u1", d1, VEC[k][3:0]);
         check("R5 no flag on legal", {3'b0, i0}, 4'd0);
      end

      // R1 reset in mid count
      @(negedge clk);
      rst = 1'b1;
      en  = 1'b1;
      @(posedge clk);
      @(posedge clk);
      #1;
      check("R1 mid-count reset u0", d0, 4'd0);
      check("R1 mid-count reset u1", d1, 4'd0);

      for (int code = 10; code <= 15; code++) begin
         upset(code[3:0], 1'b1);
         #1;
         check("R5 flag u0", {3'b0, i0}, 4'd1);
         check("R5 flag u1", {3'b0, i1}, 4'd1);
         check("R4 no carry on illegal", {3'b0, c0}, 4'd0);
         @(posedge clk);
         #1;
         mid = eq_step(code[3:0]);
         check("R6 first step u0", d0, mid);
         check("R7 fast zero u1", d1, 4'd0);
         @(posedge clk);
         #1;
         check("R8 legal within two u0", d0, eq_step(mid));
         check("R8 flag cleared u0", {3'b0, i0}, 4'd0);
      end

      // R3 illegal code held while disabled
      upset(4'd12, 1'b0);
      @(posedge clk);
      #1;
      check("R3 hold illegal u0", d0, 4'd12);
      check("R3 hold illegal u1", d1, 4'd12);
      check("R5 flag kept", {3'b0, i0}, 4'd1);
      @(negedge clk);
      en = 1'b1;
      @(posedge clk);
      #1;
      check("R6 12 to 13 u0", d0, 4'd13);
      check("R7 12 to 0 u1", d1, 4'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule